// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block divides a single input clock by a programmable fixed-point ratio and emits a one-cycle clock-enable pulse at the divided rate. The ratio word carries an integer part and a binary fraction. Each output period lasts either the integer part or one clock more. A phase accumulator on the fraction picks the length afresh for every period, so the long-run average spacing of the pulses equals the programmed ratio exactly.

Downstream logic that should run at a rate the input clock does not divide evenly qualifies its registers with the enable. Examples are a baud tick or a sample strobe. Period lengths jitter by at most one clock, and the pattern of lengths repeats within 2^FRAC_W periods. The ratio input may change at any time. It is taken only at a pulse boundary, so a period in progress is never shortened or stretched.

Top module: `frac_clk_en_div`

## Requirements
- R1: `ratio_i[9:5]` is the integer part I and `ratio_i[4:0]` the fraction F, giving a ratio of I + F/32. An integer part of 0 acts as 1, so the effective integer part Ie = max(I,1).
- R2: Every output period lasts either Ie or Ie+1 input clocks, where Ie is taken from the ratio sampled when that period began.
- R3: While `rst` is high, `en_o` stays low and the 5-bit phase accumulator clears. The first pulse after release falls in the Ie-th clock cycle, counting the first cycle with `rst` low as cycle 1.
- R4: At each pulse the accumulator adds F modulo 32. A carry out of that add makes the next period Ie+1, and otherwise the next period is Ie. The first period after reset is always Ie.
- R5: A ratio of 5.5 (`ratio_i` = 0x0B0) gives periods of 5, 5, 6, 5, 6, ... after reset, so every two consecutive periods after the first span exactly 11 clocks.
- R6: With the ratio held, the clocks between any pulse and the 32nd pulse after it total exactly 32·Ie + F.
- R7: With I ≤ 1 and F = 0 (`ratio_i` = 0x020 or 0x000), `en_o` is high on every clock cycle outside reset.
- R8: The ratio is sampled only on the clock edge that ends a pulse cycle. A change in mid-period has no effect on the current period. A change present during the pulse cycle sets the following period.
- R9: A ratio of 3.3125 (`ratio_i` = 0x06A) gives 32 periods spanning 106 clocks, which is 100 MHz / 3.3125 ≈ 30.189 MHz on average.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 10 | Division ratio: integer part in the upper 5 bits, fraction in the lower 5 |
| en_o | output | 1 | One-cycle clock-enable pulse at the divided rate |

## Verification
Sampling a new ratio and reloading the period counter share one clock edge. A ratio change therefore interacts with the reload in two distinct ways. The bench changes the ratio in the middle of a period, and again in the very cycle a pulse is high. In the first case it expects the running period to finish at its old length. In the second case it expects the new ratio to set the next period at once, including the accumulator's carry decision. The checker follows the ratio latched at each boundary. It judges every period length and every 32-pulse span against that latched ratio rather than against the live input.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int DEF_INT_W  = 5;
  localparam int DEF_FRAC_W = 5;

  // integer part of zero is clamped to one clock
  function automatic int eff_int(int ival);
    return (ival < 1) ? 1 : ival;
  endfunction

  // length of a period given the effective integer part and the carry
  function automatic int period_len(int ieff, bit carry);
    return ieff + (carry ? 1 : 0);
  endfunction

  // counter width needed to hold the longest period (2^int_w clocks)
  function automatic int cnt_width(int int_w);
    return $clog2((1 << int_w) + 1);
  endfunction

endpackage

// File: rtl/fdiv_ratio_split.sv
module fdiv_ratio_split #(
  parameter int INT_W  = fdiv_pkg::DEF_INT_W,
  parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W
) (
  input  logic [INT_W+FRAC_W-1:0] ratio_i,
  output logic [INT_W-1:0]        ieff_o,
  output logic [FRAC_W-1:0]       frac_o
);
  localparam int RW = INT_W + FRAC_W;

  always_comb begin
    ieff_o = INT_W'(fdiv_pkg::eff_int(int'(ratio_i[RW-1:FRAC_W])));
    frac_o = ratio_i[FRAC_W-1:0];
  end
endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W:0]   sum_w;

  always_comb begin
    sum_w   = {1'b0, phase_q} + {1'b0, frac_i};
    carry_o = sum_w[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (clr)
      phase_q <= '0;
    else if (step)
      phase_q <= sum_w[FRAC_W-1:0];
  end
endmodule

// File: rtl/fdiv_down_cnt.sv
module fdiv_down_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tc_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (load)
      cnt_q <= load_val;
    else
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/frac_clk_en_div.sv
module frac_clk_en_div #(
  parameter int INT_W  = fdiv_pkg::DEF_INT_W,
  parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W+FRAC_W-1:0] ratio_i,
  output logic                    en_o
);
  localparam int CNT_W = fdiv_pkg::cnt_width(INT_W);

  logic [INT_W-1:0]  ieff_w;
  logic [FRAC_W-1:0] frac_w;
  logic              carry_w;
  logic              tc_w;
  logic              reload_w;
  logic [CNT_W-1:0]  next_len_w;

  fdiv_ratio_split #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_split (
    .ratio_i (ratio_i),
    .ieff_o  (ieff_w),
    .frac_o  (frac_w)
  );

  fdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .clr     (rst),
    .step    (tc_w),
    .frac_i  (frac_w),
    .carry_o (carry_w)
  );

  // reload on reset or at the terminal count, same edge as the pulse
  always_comb begin
    reload_w = rst | tc_w;
    if (rst)
      next_len_w = CNT_W'(int'(ieff_w));
    else
      next_len_w = CNT_W'(fdiv_pkg::period_len(int'(ieff_w), carry_w));
  end

  fdiv_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .load     (reload_w),
    .load_val (next_len_w),
    .tc_o     (tc_w)
  );

  assign en_o = tc_w & ~rst;
endmodule

// File: rtl/frac_clk_en_div_chk.sv
module frac_clk_en_div_chk #(
  parameter int INT_W  = fdiv_pkg::DEF_INT_W,
  parameter int FRAC_W = fdiv_pkg::DEF_FRAC_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic [INT_W+FRAC_W-1:0] ratio_i,
  input logic                    en_o
);
  localparam int RW      = INT_W + FRAC_W;
  localparam int LW      = INT_W + 2;
  localparam int WW      = INT_W + FRAC_W + 2;
  localparam int PW      = FRAC_W + 1;
  localparam int WP_LAST = (1 << FRAC_W) - 1;

  function automatic int ie_of(logic [RW-1:0] r);
    int i;
    i = int'(r[RW-1:FRAC_W]);
    return (i == 0) ? 1 : i;
  endfunction

  function automatic int span_of(logic [RW-1:0] r);
    return (ie_of(r) << FRAC_W) + int'(r[FRAC_W-1:0]);
  endfunction

  logic [LW-1:0] plen;
  logic [LW-1:0] lat_ie;
  logic          first_q;
  logic          wact, wok;
  logic [RW-1:0] wratio;
  logic [WW-1:0] wclk;
  logic [PW-1:0] wp;

  always_ff @(posedge clk) begin
    if (rst || en_o) begin
      plen   <= LW'(1);
      lat_ie <= LW'(ie_of(ratio_i));
    end else begin
      plen <= plen + LW'(1);
    end
    if (rst)       first_q <= 1'b1;
    else if (en_o) first_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wact <= 1'b0;
      wok  <= 1'b0;
      wclk <= '0;
      wp   <= '0;
      wratio <= '0;
    end else if (en_o) begin
      if (!wact || wp == PW'(WP_LAST)) begin
        wact   <= 1'b1;
        wok    <= 1'b1;
        wratio <= ratio_i;
        wclk   <= '0;
        wp     <= '0;
      end else begin
        wp   <= wp + PW'(1);
        wclk <= wclk + WW'(1);
        if (ratio_i != wratio) wok <= 1'b0;
      end
    end else if (wact) begin
      wclk <= wclk + WW'(1);
    end
  end

  // R3: no pulse while reset is held
  a_r3_quiet_in_reset: assert property (@(posedge clk) rst |-> !en_o);

  // R3: first pulse lands exactly in cycle Ie after release
  a_r3_first_pulse: assert property (@(posedge clk) disable iff (rst)
    first_q |-> (en_o == (plen == lat_ie)));

  // R2, R8: period length is Ie or Ie+1 of the ratio latched at its start
  a_r2_len_choice: assert property (@(posedge clk) disable iff (rst)
    (!first_q && en_o) |-> (plen == lat_ie || plen == lat_ie + LW'(1)));

  // R2: no period runs past Ie+1
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    !first_q |-> (plen <= lat_ie + LW'(1)));

  // R7: unit ratio keeps the enable high
  a_r7_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (en_o && ratio_i[RW-1:FRAC_W] <= INT_W'(1) && ratio_i[FRAC_W-1:0] == '0) |=> en_o);

  // R6: 32 pulses span 32*Ie + F clocks with the ratio held
  a_r6_window_span: assert property (@(posedge clk) disable iff (rst)
    (wact && en_o && wp == PW'(WP_LAST) && wok) |-> (wclk + WW'(1) == WW'(span_of(wratio))));
endmodule

bind frac_clk_en_div frac_clk_en_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ratio_i (ratio_i),
  .en_o    (en_o)
);

// File: tb/frac_clk_en_div_bench.sv
`timescale 1ns/1ps
module frac_clk_en_div_bench;
  typedef struct packed {
    logic [9:0]  ratio;
    logic [10:0] span32;
  } vec_t;

  localparam int NV = 8;
  // expected 32-period spans worked out by hand as 32*Ie + F
  localparam vec_t VECS [NV] = '{
    '{10'h3FF, 11'd1023},
    '{10'h0B0, 11'd176},
    '{10'h06A, 11'd106},
    '{10'h020, 11'd32},
    '{10'h000, 11'd32},
    '{10'h010, 11'd48},
    '{10'h0E1, 11'd225},
    '{10'h040, 11'd64}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] ratio = '0;
  logic       en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  frac_clk_en_div u_frac_clk_en_div (
    .clk     (clk),
    .rst     (rst),
    .ratio_i (ratio),
    .en_o    (en)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (R2) actual=%0d cycles expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [9:0] r);
    @(posedge clk); #1;
    rst = 1'b1;
    ratio = r;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // counts cycles up to and including the next pulse cycle
  task automatic get_period(output int len);
    len = 0;
    forever begin
      @(negedge clk); #0.5;
      len++;
      if (en) break;
    end
  endtask

  function automatic string tag_of(int idx);
    case (idx)
      1: return "R5";
      2: return "R9";
      3: return "R7";
      4: return "R7 R1";
      5: return "R1";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int len, prev, ie, f, acc, s, exp, sum;

    // R3: enable low under reset even for a unit ratio
    rst = 1'b1;
    ratio = 10'h020;
    repeat (2) @(posedge clk);
    @(negedge clk); #0.5;
    chk(en == 1'b0, "R3 reset state", int'(en), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].ratio);
      ie  = int'(VECS[i].ratio[9:5]);
      if (ie == 0) ie = 1;
      f   = int'(VECS[i].ratio[4:0]);
      acc = 0;
      get_period(len);
      chk(len == ie, "R3 first period", len, ie);
      sum  = 0;
      prev = 0;
      for (int k = 0; k < 32; k++) begin
        s   = acc + f;
        exp = ie + ((s >= 32) ? 1 : 0);
        acc = s % 32;
        get_period(len);
        chk(len == exp, {"R2 R4 ", tag_of(i)}, len, exp);
        if (i == 1 && k > 0 && (k % 2) == 1)
          chk(prev + len == 11, "R5 pair span", prev + len, 11);
        prev = len;
        sum += len;
      end
      chk(sum == int'(VECS[i].span32), {"R6 ", tag_of(i)}, sum, int'(VECS[i].span32));
    end

    // R8: mid-period change ignored, change during pulse cycle takes effect
    do_reset(10'h140);
    @(negedge clk); #0.5;
    chk(en == 1'b0, "R8 cycle1 no pulse", int'(en), 0);
    ratio = 10'h0B0;
    get_period(len);
    chk(len == 9, "R8 running period kept", len, 9);
    get_period(len);
    chk(len == 5, "R8 new ratio next period", len, 5);
    ratio = 10'h040;
    get_period(len);
    chk(len == 2, "R8 change in pulse cycle", len, 2);
    get_period(len);
    chk(len == 2, "R8 settled", len, 2);

    // R4: reset clears accumulator left nonzero by a previous run
    do_reset(10'h0B0);
    get_period(len);
    chk(len == 5, "R4 after re-reset p1", len, 5);
    get_period(len);
    chk(len == 5, "R4 after re-reset p2", len, 5);
    get_period(len);
    chk(len == 6, "R4 after re-reset p3", len, 6);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule